// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block connects a clocked host port to an asynchronous 64K x 16 static RAM whose chip select, write strobe, output enable and two byte-lane selects are all active low. The host offers a request with a valid/ready handshake: a write flag, a 16-bit word address, 16 bits of write data and one enable bit per byte lane. The controller turns each request into a full RAM cycle. It sequences the control pins so that address setup, strobe width, output-enable access, data setup and data hold are each covered by a whole number of clock cycles. These counts come from parameters for the clock period and for the RAM's cycle and access times.

Writes lower the write strobe in the same clock as the chip and lane selects, never after them, so the RAM never turns its outputs on during a write. The controller drives its data pins only once the strobe is low. It raises the strobe before any select, which makes the strobe's rising edge the edge that captures the data, and it keeps driving data for a hold interval after that edge. Reads drop output enable after the address setup and capture the bus at the end of the access window. The byte lanes that were not requested read back as zero. A request with no lane enabled completes at once without touching the RAM. Every request ends with a one-cycle response pulse.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no request is in progress, chip select, write strobe, output enable and both lane selects are high, the data drivers are off, and `req_ready` is high.
- R2: A write with both enables set stores all 16 bits of `req_wdata` at `req_addr`.
- R3: Enable bit 0 controls lane select bit 0, which covers data bits 7:0. Enable bit 1 controls lane select bit 1, which covers bits 15:8. The select of a disabled lane stays high for the whole request, so the RAM byte in that lane keeps its value.
- R4: A read returns the RAM data on the enabled lanes in `rsp_rdata` and zero on the disabled lanes.
- R5: During a write's address setup, chip select and the lane selects stay high. The write strobe falls in the same clock as they do, and it is low only while chip select and at least one lane select are low.
- R6: The data drivers are off in the first cycle the strobe is low and on for the rest of the strobe. They are never on while output enable is low.
- R7: A write ends with the strobe rising while chip select and the lane selects are still low and data is still driven. This state lasts HOLD_CYC cycles (1 by default).
- R8: `ram_addr` holds the request address unchanged for as long as chip select is low.
- R9: With defaults (10 ns clock, 100 ns cycle, 50 ns output-enable access, one setup cycle), the strobe is low for 8 cycles and output enable is low for 9 cycles. `rsp_valid` rises 10 cycles after the accepting edge for both reads and writes.
- R10: A request with both enables clear raises `rsp_valid` in the cycle right after it is accepted, and chip select stays high.
- R11: `req_ready` is low while a RAM cycle is in progress, and `rsp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 16 | RAM address pins |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_bsel_n | output | 2 | RAM lane selects, active low, bit 0 = bits 7:0 |
| ram_dq_out | output | 16 | Data to the bus pad drivers |
| ram_dq_oe | output | 1 | Pad driver enable |
| ram_dq_in | input | 16 | Data from the bus pads |

## Verification
Counting from the clock edge that accepts a request, the address-setup state is seen one cycle later. Write strobe cycles follow at offsets 1 to 8, the hold state at offset 9, and `rsp_valid` at offset 10. Read access cycles run at offsets 1 to 9, and the captured data appears with `rsp_valid` at offset 10. A request with no lanes enabled shows `rsp_valid` at offset 0. The bench drives inputs and samples outputs on falling edges, records twelve offsets per request, and compares each offset with the value the requirements set for it. A bus model stores write data on the edge where the write condition ends and counts any cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_ACCESS
  } phase_e;

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_on,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (load_en) begin
      wdata_q <= wdata_in;
    end
  end

  assign dq_out = wdata_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (capture) begin
        byte_q <= lane_on[g] ? dq_in[g*8 +: 8] : 8'h00;
      end
    end
    assign rdata[g*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned CLK_NS         = 10,
  parameter int unsigned CYCLE_NS       = 100,
  parameter int unsigned OE_ACC_NS      = 50,
  parameter int unsigned ADDR_SETUP_CYC = 1,
  parameter int unsigned HOLD_CYC       = 1,
  localparam int unsigned LANES         = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [LANES-1:0]  ram_bsel_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int unsigned CYC_CLKS   = ceil_div(CYCLE_NS, CLK_NS);
  localparam int unsigned OE_CLKS    = ceil_div(OE_ACC_NS, CLK_NS);
  localparam int unsigned ACC_CLKS   = max_u(max_u(CYC_CLKS, ADDR_SETUP_CYC + OE_CLKS),
                                             ADDR_SETUP_CYC + 1) - ADDR_SETUP_CYC;
  localparam int unsigned PULSE_CLKS = max_u(CYC_CLKS, ADDR_SETUP_CYC + HOLD_CYC + 2)
                                       - ADDR_SETUP_CYC - HOLD_CYC;
  localparam int unsigned MAX_LD     = max_u(max_u(ACC_CLKS, PULSE_CLKS),
                                             max_u(ADDR_SETUP_CYC, HOLD_CYC));
  localparam int unsigned CNT_W      = $clog2(MAX_LD + 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(ADDR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CLKS - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(ACC_CLKS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  phase_e            phase_q, phase_d;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept, capture, rsp_d;
  logic              rsp_q, first_q;
  logic              wr_q;
  logic [LANES-1:0]  lane_q;
  logic [ADDR_W-1:0] addr_q;

  assign accept = req_valid && (phase_q == PH_IDLE);

  // next phase
  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rsp_d    = 1'b0;
    capture  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (req_be == '0) begin
            rsp_d = 1'b1;
          end else begin
            phase_d  = PH_SETUP;
            tmr_load = 1'b1;
            tmr_val  = LD_SETUP;
          end
        end
      end
      PH_SETUP: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (wr_q) begin
            phase_d = PH_STROBE;
            tmr_val = LD_PULSE;
          end else begin
            phase_d = PH_ACCESS;
            tmr_val = LD_ACC;
          end
        end
      end
      PH_STROBE: begin
        if (tmr_expired) begin
          phase_d  = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
        end
      end
      PH_HOLD: begin
        if (tmr_expired) begin
          phase_d = PH_IDLE;
          rsp_d   = 1'b1;
        end
      end
      PH_ACCESS: begin
        if (tmr_expired) begin
          phase_d = PH_IDLE;
          rsp_d   = 1'b1;
          capture = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      rsp_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rsp_q   <= rsp_d;
      first_q <= (phase_d == PH_STROBE) && (phase_q != PH_STROBE);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      lane_q <= '0;
      addr_q <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      lane_q <= req_be;
      addr_q <= req_addr;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_lane_path #(.DATA_W(DATA_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load_en  (accept),
    .wdata_in (req_wdata),
    .capture  (capture),
    .lane_on  (lane_q),
    .dq_in    (ram_dq_in),
    .dq_out   (ram_dq_out),
    .rdata    (rsp_rdata)
  );

  // pin decode from registered phase
  logic sel_on;
  assign sel_on = (phase_q == PH_STROBE) || (phase_q == PH_HOLD) ||
                  (phase_q == PH_ACCESS) || ((phase_q == PH_SETUP) && !wr_q);

  assign ram_addr   = addr_q;
  assign ram_cs_n   = !sel_on;
  assign ram_bsel_n = ~(lane_q & {LANES{sel_on}});
  assign ram_we_n   = (phase_q != PH_STROBE);
  assign ram_oe_n   = (phase_q != PH_ACCESS);
  assign ram_dq_oe  = ((phase_q == PH_STROBE) && !first_q) || (phase_q == PH_HOLD);
  assign req_ready  = (phase_q == PH_IDLE);
  assign rsp_valid  = rsp_q;

  // R6: pad drivers never fight the RAM outputs
  p_drv_vs_oe_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    ram_dq_oe |-> ram_oe_n);
  // R6: drivers wait for the strobe to be low
  p_drv_late_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ram_we_n) |-> !ram_dq_oe);
  // R5: strobe low only inside an active select
  p_strobe_in_sel_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !ram_we_n |-> (!ram_cs_n && !(&ram_bsel_n)));
  // R5: a write's select falls together with the strobe
  p_sel_with_we_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(ram_cs_n) && wr_q) |-> $fell(ram_we_n));
  // R7: strobe is the first control to rise, data still driven
  p_we_first_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ram_we_n) |-> (!ram_cs_n && ram_dq_oe));
  // R8: address frozen while selected
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));
  // R11: single-cycle response, busy after a real request
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |=> !rsp_valid);
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready && (req_be != '0)) |=> !req_ready);
  // R10: empty request finishes at once without selecting the RAM
  p_zero_be_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready && (req_be == '0)) |=> (rsp_valid && ram_cs_n));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int N_SMP   = 12;
  localparam int PULSE_E = 8;
  localparam int ACC_E   = 9;
  localparam int LAT_E   = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] ram_addr;
  logic        ram_cs_n, ram_we_n, ram_oe_n;
  logic [1:0]  ram_bsel_n;
  logic [15:0] ram_dq_out;
  logic        ram_dq_oe;
  logic [15:0] ram_dq_in;

  int n_checks = 0;
  int n_fail   = 0;
  int n_clash  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_bsel_n(ram_bsel_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // bus model of the asynchronous RAM (256 words mirrored)
  logic [15:0] mem [256];
  logic        prev_wr;
  logic [1:0]  prev_lanes;

  for (genvar g = 0; g < 2; g++) begin : g_bus
    assign ram_dq_in[g*8 +: 8] =
      (!ram_cs_n && !ram_oe_n && ram_we_n && !ram_bsel_n[g]) ?
      mem[ram_addr[7:0]][g*8 +: 8] : 8'hA5;
  end

  always @(negedge clk) begin
    if (ram_dq_oe && !ram_oe_n) n_clash++;
    if (prev_wr && !(!ram_cs_n && !ram_we_n && !(&ram_bsel_n))) begin
      for (int l = 0; l < 2; l++) begin
        if (!prev_lanes[l])
          mem[ram_addr[7:0]][l*8 +: 8] = ram_dq_oe ? ram_dq_out[l*8 +: 8] : 8'hXX;
      end
    end
    prev_wr    = !ram_cs_n && !ram_we_n && !(&ram_bsel_n);
    prev_lanes = ram_bsel_n;
  end

  // per-offset samples of one request
  logic        s_we  [N_SMP];
  logic        s_oe  [N_SMP];
  logic        s_cs  [N_SMP];
  logic [1:0]  s_bs  [N_SMP];
  logic        s_drv [N_SMP];
  logic        s_rsp [N_SMP];
  logic        s_rdy [N_SMP];
  logic [15:0] s_adr [N_SMP];
  logic [15:0] got_rdata;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic wr, input logic [15:0] a,
                         input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_rdata = 16'h0;
    for (int n = 0; n < N_SMP; n++) begin
      if (n > 0) @(negedge clk);
      s_we[n] = ram_we_n;  s_oe[n] = ram_oe_n;  s_cs[n] = ram_cs_n;
      s_bs[n] = ram_bsel_n; s_drv[n] = ram_dq_oe; s_rsp[n] = rsp_valid;
      s_rdy[n] = req_ready; s_adr[n] = ram_addr;
      if (rsp_valid) got_rdata = rsp_rdata;
    end
  endtask

  function automatic int count_low(input logic v [N_SMP]);
    int c = 0;
    for (int n = 0; n < N_SMP; n++) if (!v[n]) c++;
    return c;
  endfunction

  function automatic int first_rsp();
    for (int n = 0; n < N_SMP; n++) if (s_rsp[n]) return n;
    return -1;
  endfunction

  task automatic check_addr_held(input logic [15:0] a);
    int bad = 0;
    for (int n = 0; n < N_SMP; n++) if (!s_cs[n] && s_adr[n] !== a) bad++;
    check("R8", "address changes while selected", bad, 0);
  endtask

  task automatic t_reset();
    check("R1", "idle pins {cs,we,oe,bsel,drv,rdy,rsp}",
          {ram_cs_n, ram_we_n, ram_oe_n, ram_bsel_n, ram_dq_oe, req_ready, rsp_valid},
          {1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0});
  endtask

  task automatic t_word_write();
    run_req(1'b1, 16'h0012, 16'hBEEF, 2'b11);
    check("R5", "write setup cs/bsel/we", {s_cs[0], s_bs[0], s_we[0]}, {1'b1, 2'b11, 1'b1});
    check("R5", "strobe and selects fall together", {s_we[1], s_cs[1], s_bs[1]}, {1'b0, 1'b0, 2'b00});
    check("R9", "strobe low cycles", count_low(s_we), PULSE_E);
    check("R6", "drivers off in first strobe cycle", s_drv[1], 1'b0);
    check("R6", "drivers on in second strobe cycle", s_drv[2], 1'b1);
    check("R7", "hold {we,cs,drv}", {s_we[9], s_cs[9], s_drv[9]}, {1'b1, 1'b0, 1'b1});
    check("R1", "drivers released after hold", s_drv[10], 1'b0);
    check("R9", "write response offset", first_rsp(), LAT_E);
    check("R11", "response pulse width", {s_rsp[10], s_rsp[11]}, 2'b10);
    check("R11", "ready low while busy", s_rdy[5], 1'b0);
    check_addr_held(16'h0012);
    check("R2", "word stored", mem[8'h12], 16'hBEEF);
  endtask

  task automatic t_word_read();
    run_req(1'b0, 16'h0012, 16'h0000, 2'b11);
    check("R9", "output enable low cycles", count_low(s_oe), ACC_E);
    check("R9", "read response offset", first_rsp(), LAT_E);
    check("R4", "word read data", got_rdata, 16'hBEEF);
    check("R1", "idle after read {cs,oe,rdy}", {s_cs[11], s_oe[11], s_rdy[11]}, 3'b111);
    check_addr_held(16'h0012);
  endtask

  task automatic t_byte_write();
    int lo_low = 0;
    run_req(1'b1, 16'h0012, 16'h1277, 2'b10);
    for (int n = 0; n < N_SMP; n++) if (!s_bs[n][0]) lo_low++;
    check("R3", "low lane select stays high", lo_low, 0);
    check("R3", "upper byte only written", mem[8'h12], 16'h12EF);
    run_req(1'b1, 16'h0040, 16'h99C3, 2'b01);
    check("R3", "lower byte only written", mem[8'h40], {8'h40 ^ 8'h3C, 8'hC3});
  endtask

  task automatic t_byte_read();
    run_req(1'b0, 16'h0012, 16'h0000, 2'b01);
    check("R4", "lower lane read, upper zero", got_rdata, 16'h00EF);
    run_req(1'b0, 16'h0012, 16'h0000, 2'b10);
    check("R4", "upper lane read, lower zero", got_rdata, 16'h1200);
  endtask

  task automatic t_empty();
    int cs_low;
    run_req(1'b1, 16'h0070, 16'h5555, 2'b00);
    cs_low = count_low(s_cs);
    check("R10", "empty request response offset", first_rsp(), 0);
    check("R10", "chip select low cycles", cs_low, 0);
    check("R10", "RAM word untouched", mem[8'h70], {8'h70 ^ 8'h3C, 8'h70});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'h3C, 8'(i)};
    prev_wr = 1'b0; prev_lanes = 2'b11;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_word_write();
    t_word_read();
    t_byte_write();
    t_byte_read();
    t_empty();
    check("R6", "bus contention cycles", n_clash, 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule